// File: doc/BRIEF.md
# Byte-Banked Unaligned Word Memory

This block is a 32-bit memory split into four byte-wide banks, each with its own address. A request carries a byte address that need not be a multiple of four. Any access, aligned or not, completes in one cycle. For each bank, the block chooses either the base word address or the word after it, and a lane rotation moves the bytes into the right order. A word that straddles two stored words therefore costs one access rather than two.

A request can be a 32-bit read or a write of one, two or four bytes. Reads return the four bytes starting at the given byte address, lowest address in the least significant lane, one clock after the request. Writes take their bytes from the low lanes of the write data. Only the banks covering those bytes are written, and every other byte keeps its value. Addresses that run past the top of memory continue at byte address 0.

Top module: `banked_word_mem`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `rdData` is zero.
- R2: On an aligned word read, lane i (bits 8i+7:8i) of `rdData` holds the byte at address `addr`+i. Bits 1:0 of `addr` are 0 for an aligned access.
- R3: A read at byte offset 1, 2 or 3 (`addr[1:0]`) returns the bytes `addr`..`addr`+3 in a single access. Banks below the offset take the next word address and the other banks take the base word address.
- R4: Read data appears on `rdData` on the clock edge after the request and then holds until the next read request.
- R5: A read issued in the cycle right after a write returns the newly written bytes.
- R6: A byte write (`size`=2'b00) stores `wrData[7:0]` at `addr` and leaves all other bytes unchanged.
- R7: A halfword write (`size`=2'b01) stores `wrData[15:0]` at `addr` and `addr`+1, low byte first. This also holds when the two bytes lie in different words.
- R8: A word write (`size`=2'b10) at any byte offset stores all four bytes of `wrData` at `addr`..`addr`+3, low byte first. An unaligned write therefore spans two words.
- R9: Byte addresses beyond the top of memory wrap to address 0, for both reads and writes.
- R10: `size`=2'b11 behaves exactly as a word access.
- R11: A write request leaves `rdData` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request valid this cycle |
| wrEn | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address |
| size | input | 2 | Write width: 00 byte, 01 halfword, 1x word |
| wrData | input | 32 | Write data, low lanes used first |
| rdData | output | 32 | Registered read data |

## Verification
The bench builds the block with `ADDR_W` = 6, which gives 16 words per bank and 64 bytes in total. At that size the bench can fill every location from a known state. The last few byte addresses, where accesses wrap to address 0, are only a handful of requests away. The small size also lets the bench reach the case where the next-word increment overflows to word 0 on every offset.

// File: rtl/bbm_pkg.sv
package bbm_pkg;
  localparam int LANES = 4;
  localparam int OFF_W = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WORD_ALT = 2'b11
  } accSize_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic [LANES-1:0] plusOne;  // bank uses next word address
    logic [LANES-1:0] bankWe;   // per-bank write enable
    logic [OFF_W-1:0] rot;      // lane rotation amount
    logic             rdStb;    // capture read data
  } bankStrb_t;
endpackage

// File: rtl/bbm_ctrl.sv
module bbm_ctrl
  import bbm_pkg::*;
(
  input  logic             req,
  input  logic             wrEn,
  input  logic [OFF_W-1:0] offset,
  input  logic [1:0]       size,
  output bankStrb_t        strb
);
  logic [LANES-1:0] laneMask;

  always_comb begin
    case (size)
      SZ_BYTE: laneMask = LANES'(1);
      SZ_HALF: laneMask = LANES'(3);
      default: laneMask = '1;
    endcase
  end

  always_comb begin
    strb = '0;
    strb.rot = offset;
    strb.rdStb = req && !wrEn;
    for (int b = 0; b < LANES; b++) begin
      logic [OFF_W-1:0] lane;
      lane = OFF_W'(b) - offset;
      strb.plusOne[b] = OFF_W'(b) < offset;
      strb.bankWe[b] = req && wrEn && laneMask[lane];
    end
  end
endmodule

// File: rtl/bbm_datapath.sv
module bbm_datapath
  import bbm_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  bankStrb_t            strb,
  input  logic [WORD_W-1:0]    wordAddr,
  input  logic [8*LANES-1:0]   wrData,
  output logic [8*LANES-1:0]   rdData
);
  localparam int DEPTH = 1 << WORD_W;

  logic [7:0]       bankQ [LANES];
  logic [OFF_W-1:0] rotQ;

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic [7:0]        mem [DEPTH];
    logic [WORD_W-1:0] bankAddr;
    logic [OFF_W-1:0]  srcLane;
    logic [7:0]        q;

    assign bankAddr = wordAddr + WORD_W'(strb.plusOne[b]);
    assign srcLane  = OFF_W'(b) - strb.rot;

    always_ff @(posedge clk) begin
      if (strb.bankWe[b]) mem[bankAddr] <= wrData[8*srcLane +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (strb.rdStb) q <= mem[bankAddr];
    end

    assign bankQ[b] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rotQ <= '0;
    else if (strb.rdStb) rotQ <= strb.rot;
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      rdData[8*i +: 8] = bankQ[OFF_W'(i) + rotQ];
    end
  end
endmodule

// File: rtl/banked_word_mem.sv
module banked_word_mem
  import bbm_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData
);
  localparam int WORD_W = ADDR_W - OFF_W;

  bankStrb_t strb;

  bbm_ctrl u_ctrl (
    .req    (req),
    .wrEn   (wrEn),
    .offset (addr[OFF_W-1:0]),
    .size   (size),
    .strb   (strb)
  );

  bbm_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .wordAddr (addr[ADDR_W-1:OFF_W]),
    .wrData   (wrData),
    .rdData   (rdData)
  );
endmodule

// File: rtl/bbm_checker.sv
module bbm_checker
  import bbm_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        size,
  input logic [31:0]       rdData,
  input bankStrb_t         strb
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> rdData == 32'h0);

  p_aligned_same_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req && addr[1:0] == 2'b00 |-> strb.plusOne == '0);

  p_next_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> $countones(strb.plusOne) == int'(addr[1:0]) && !strb.plusOne[LANES-1]);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req && !wrEn) |-> $stable(rdData));

  p_byte_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req && wrEn && size == SZ_BYTE |-> $countones(strb.bankWe) == 1 && strb.bankWe[addr[1:0]]);

  p_half_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req && wrEn && size == SZ_HALF |-> $countones(strb.bankWe) == 2 && strb.bankWe[addr[1:0]]);

  p_word_lane_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req && wrEn && size[1] |-> strb.bankWe == '1);

  p_read_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && wrEn) |-> strb.bankWe == '0);
endmodule

bind banked_word_mem bbm_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .req    (req),
  .wrEn   (wrEn),
  .addr   (addr),
  .size   (size),
  .rdData (rdData),
  .strb   (strb)
);

// File: tb/banked_word_mem_tb_top.sv
module banked_word_mem_tb_top;
  localparam int ADDR_W = 6;
  localparam int MEM_BYTES = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req;
  logic              wrEn;
  logic [ADDR_W-1:0] addr;
  logic [1:0]        size;
  logic [31:0]       wrData;
  logic [31:0]       rdData;

  logic [7:0]  refMem [MEM_BYTES];
  logic [31:0] expRd;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  banked_word_mem #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .wrEn(wrEn),
    .addr(addr), .size(size), .wrData(wrData), .rdData(rdData)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] refRead(int a);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = refMem[(a + i) % MEM_BYTES];
    return r;
  endfunction

  // Called at a falling edge; returns at the next falling edge after checking
  task automatic doOp(bit w, int a, logic [1:0] sz, logic [31:0] d, string tag);
    int n;
    req = 1'b1; wrEn = w; addr = ADDR_W'(a); size = sz; wrData = d;
    if (w) begin
      n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
      for (int i = 0; i < n; i++) refMem[(a + i) % MEM_BYTES] = d[8*i +: 8];
    end else begin
      expRd = refRead(a);
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, rdData, expRd);
  endtask

  task automatic idle(string tag);
    req = 1'b0; wrEn = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(tag, rdData, expRd);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R4 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; wrEn = 1'b0; addr = '0; size = '0; wrData = '0;
    expRd = 32'h0;
    repeat (3) @(negedge clk);
    check("R1 in reset", rdData, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", rdData, 32'h0);

    // Fill with aligned word writes; rdData must hold (R11)
    for (int w = 0; w < MEM_BYTES / 4; w++)
      doOp(1, w * 4, 2'b10, 32'h9E3779B9 * (w + 1) ^ 32'h5A5A0000, "R11 write holds");

    // R2 aligned reads
    doOp(0, 0, 2'b10, 0, "R2 aligned read");
    doOp(0, 12, 2'b10, 0, "R2 aligned read");
    doOp(0, 36, 2'b10, 0, "R2 aligned read");

    // R3 unaligned reads
    for (int k = 1; k < 4; k++) begin
      doOp(0, 8 + k, 2'b10, 0, "R3 unaligned read");
      doOp(0, 20 + k, 2'b10, 0, "R3 unaligned read");
    end

    // R4 hold while idle
    idle("R4 hold idle");
    idle("R4 hold idle");

    // R6 byte writes at each offset
    for (int k = 0; k < 4; k++) begin
      doOp(1, 16 + k, 2'b00, 32'hFFFFFF10 + k, "R11 write holds");
      doOp(0, 16, 2'b10, 0, "R6 byte write");
      doOp(0, 14, 2'b10, 0, "R6 neighbours unchanged");
      doOp(0, 18, 2'b10, 0, "R6 neighbours unchanged");
    end

    // R7 halfword writes, aligned and straddling
    doOp(1, 24, 2'b01, 32'hAAAA1234, "R11 write holds");
    doOp(0, 24, 2'b10, 0, "R7 halfword aligned");
    doOp(1, 31, 2'b01, 32'hBBBBC0DE, "R11 write holds");
    doOp(0, 28, 2'b10, 0, "R7 halfword straddle low");
    doOp(0, 32, 2'b10, 0, "R7 halfword straddle high");

    // R8 unaligned word writes
    for (int k = 1; k < 4; k++) begin
      doOp(1, 40 + k, 2'b10, 32'hC0FFEE00 + k, "R11 write holds");
      doOp(0, 40, 2'b10, 0, "R8 unaligned write low word");
      doOp(0, 44, 2'b10, 0, "R8 unaligned write high word");
    end

    // R5 read right after write
    doOp(1, 50, 2'b10, 32'h13579BDF, "R11 write holds");
    doOp(0, 50, 2'b10, 0, "R5 read after write");
    doOp(1, 51, 2'b00, 32'h000000EE, "R11 write holds");
    doOp(0, 49, 2'b10, 0, "R5 read after byte write");

    // R9 wrap at top of memory
    for (int k = 1; k < 4; k++) doOp(0, MEM_BYTES - k, 2'b10, 0, "R9 read wrap");
    doOp(1, MEM_BYTES - 2, 2'b10, 32'hDEADBEEF, "R11 write holds");
    doOp(0, 0, 2'b10, 0, "R9 write wrap to zero");
    doOp(0, MEM_BYTES - 4, 2'b10, 0, "R9 write wrap top word");
    doOp(1, MEM_BYTES - 1, 2'b01, 32'h00007788, "R11 write holds");
    doOp(0, MEM_BYTES - 1, 2'b10, 0, "R9 halfword wrap");

    // R10 size 11 acts as word
    doOp(1, 6, 2'b11, 32'h0BADF00D, "R11 write holds");
    doOp(0, 4, 2'b10, 0, "R10 size 11 low word");
    doOp(0, 8, 2'b10, 0, "R10 size 11 high word");
    doOp(0, 6, 2'b11, 0, "R10 size 11 read");

    idle("R4 hold idle");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule